// File: doc/BRIEF.md
# Dual-Rail Power-Switch Sequencer

This block brings the two power-switch rails of one power domain up or down in a fixed order. The logic rail feeds the domain's logic. The array rail feeds its memory arrays. A single-cycle start pulse carries an operation (on or off) and a rail selection (logic only, array only, or both). The block first confirms that the switch hardware reports no activity. It then commands each selected rail through its switch controller, one rail at a time.

Each rail is commanded with a two-bit force code. The block then waits for that rail's four-bit gate state to return to the idle code. While it waits, a cycle counter sized to a configurable number of milliseconds guards against a hung controller. Once the idle code is seen, the block can also check that the rail's switch-select readback sits at the off encode point. The rail's command then drops back to no-operation before the next rail is touched. The end of every request is marked by a one-cycle done pulse, with error or timeout flags alongside it. The value-override, select-override and regulation-finger controls are driven inactive throughout.

There is no data stream here, so every pin is a plain control or status signal. A caller pulses start while busy is low and waits for done; it needs no handshake.

Top module: `pwr_rail_seq`

## Requirements
- R1: With the on operation (op_on_i=1) and both rails selected, the logic rail is commanded first and the array rail second, each with force code 2'b11.
- R2: With the off operation (op_on_i=0) and both rails selected, the array rail is commanded first and the logic rail second, each with force code 2'b01.
- R3: A force output only ever shows 2'b00 (no operation), 2'b01 (off) or 2'b11 (on). At most one rail shows a non-zero code at any time.
- R4: If sw_busy_i is not 4'b0000 when start is accepted, no rail is commanded. On the next cycle done_o and err_o pulse together.
- R5: A commanded rail is complete only after its gate state has left 4'b1000 and then returned to 4'b1000 (idle). Until then its command is held.
- R6: A rail that does not complete within CYCLES_PER_MS*TIMEOUT_MS cycles of being commanded aborts the request. All force codes return to 2'b00, and done_o pulses with timeout_o. If the first rail times out, done_o rises exactly TMO_CYCLES+1 cycles after the start edge.
- R7: After a rail completes, its force code is 2'b00 for at least one cycle before the other rail's code becomes non-zero.
- R8: Both value-override outputs, both select-override outputs and the logic rail's regulation-finger enable stay 0 at all times.
- R9: With CHECK_SEL=1, if a rail reaches idle while its switch-select readback is not 4'h8, the request aborts with done_o and err_o.
- R10: rail_sel_i=2'b01 commands only the logic rail and 2'b10 only the array rail. 2'b00 is refused with err_o and no rail is commanded.
- R11: done_o is high for exactly one cycle per accepted request. A start pulse while busy_o is high is ignored and does not change the running sequence.
- R12: After reset, both force codes are 2'b00 and busy_o, done_o, err_o and timeout_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, sampled while busy_o is low |
| op_on_i | input | 1 | 1 = power on, 0 = power off |
| rail_sel_i | input | 2 | bit0 = logic rail, bit1 = array rail |
| sw_busy_i | input | 4 | Switch hardware busy bits, must be zero to start |
| logic_gate_st_i | input | 4 | Logic rail gate state (4'b1000 = idle) |
| logic_sel_st_i | input | 4 | Logic rail switch-select readback |
| array_gate_st_i | input | 4 | Array rail gate state (4'b1000 = idle) |
| array_sel_st_i | input | 4 | Array rail switch-select readback |
| logic_force_o | output | 2 | Logic rail force command |
| array_force_o | output | 2 | Array rail force command |
| logic_val_ovr_o | output | 1 | Logic rail value override, held 0 |
| logic_sel_ovr_o | output | 1 | Logic rail select override, held 0 |
| logic_reg_en_o | output | 1 | Logic rail regulation-finger enable, held 0 |
| array_val_ovr_o | output | 1 | Array rail value override, held 0 |
| array_sel_ovr_o | output | 1 | Array rail select override, held 0 |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle end-of-request pulse |
| err_o | output | 1 | Refusal or select error, valid with done_o |
| timeout_o | output | 1 | Timeout abort, valid with done_o |

## Verification
The properties assume that start_i is a pulse and that each switch controller behaves like a real one. A controller leaves the idle code some cycles after a non-zero force appears, and returns to idle later unless it is hung. The bench keeps to this with a per-rail responder model. The model goes busy one cycle after it sees a command, returns to idle after a random delay, and resets once the command drops. Random requests mix both operations, every rail selection, busy bits, hung controllers and bad select readbacks. Directed cases pin the exact timeout cycle and a start pulse injected mid-sequence.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    FORCE_NOP = 2'b00,
    FORCE_OFF = 2'b01,
    FORCE_ON  = 2'b11
  } force_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_WAIT,
    S_REL,
    S_FIN
  } seq_st_e;

  localparam int unsigned NRAIL = 2;
  localparam int unsigned RAIL_LOGIC = 0;
  localparam int unsigned RAIL_ARRAY = 1;
  localparam logic [3:0] GATE_IDLE = 4'b1000;
  localparam logic [3:0] SEL_OFF = 4'h8;
endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int unsigned LIMIT = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/pwr_seq_rail_drv.sv
module pwr_seq_rail_drv
  import pwr_seq_pkg::*;
(
  input  logic       act_i,
  input  logic [1:0] cmd_i,
  input  logic [3:0] gate_st_i,
  input  logic [3:0] sel_st_i,
  output logic [1:0] force_o,
  output logic       idle_o,
  output logic       selok_o
);
  assign force_o = act_i ? cmd_i : FORCE_NOP;
  assign idle_o  = (gate_st_i == GATE_IDLE);
  assign selok_o = (sel_st_i == SEL_OFF);
endmodule

// File: rtl/pwr_seq_ctl.sv
module pwr_seq_ctl
  import pwr_seq_pkg::*;
#(
  parameter bit CHECK_SEL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             op_on_i,
  input  logic [1:0]       rail_sel_i,
  input  logic [3:0]       sw_busy_i,
  input  logic [NRAIL-1:0] rail_idle_i,
  input  logic [NRAIL-1:0] rail_selok_i,
  input  logic             tmo_i,
  output logic [NRAIL-1:0] rail_act_o,
  output logic [1:0]       cmd_o,
  output logic             tmr_en_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             timeout_o
);
  seq_st_e st_q;
  logic op_q, cur_q, pend_q, seen_q, err_q, tmo_q;
  logic idle_c, selok_c;

  assign idle_c  = rail_idle_i[cur_q];
  assign selok_c = rail_selok_i[cur_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      op_q   <= 1'b0;
      cur_q  <= 1'b0;
      pend_q <= 1'b0;
      seen_q <= 1'b0;
      err_q  <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: begin
          if (start_i) begin
            tmo_q  <= 1'b0;
            seen_q <= 1'b0;
            if (sw_busy_i != 4'b0000 || rail_sel_i == 2'b00) begin
              err_q <= 1'b1;
              st_q  <= S_FIN;
            end else begin
              err_q <= 1'b0;
              op_q  <= op_on_i;
              st_q  <= S_WAIT;
              if (rail_sel_i == 2'b11) begin
                // on: logic first; off: array first
                cur_q  <= op_on_i ? 1'(RAIL_LOGIC) : 1'(RAIL_ARRAY);
                pend_q <= 1'b1;
              end else begin
                cur_q  <= rail_sel_i[0] ? 1'(RAIL_LOGIC) : 1'(RAIL_ARRAY);
                pend_q <= 1'b0;
              end
            end
          end
        end
        S_WAIT: begin
          if (!seen_q && !idle_c) begin
            seen_q <= 1'b1;
          end
          if (seen_q && idle_c) begin
            if (CHECK_SEL && !selok_c) begin
              err_q <= 1'b1;
              st_q  <= S_FIN;
            end else begin
              st_q <= S_REL;
            end
          end else if (tmo_i) begin
            tmo_q <= 1'b1;
            st_q  <= S_FIN;
          end
        end
        S_REL: begin
          if (pend_q) begin
            pend_q <= 1'b0;
            cur_q  <= ~cur_q;
            seen_q <= 1'b0;
            st_q   <= S_WAIT;
          end else begin
            st_q <= S_FIN;
          end
        end
        S_FIN: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    rail_act_o = '0;
    if (st_q == S_WAIT) rail_act_o[cur_q] = 1'b1;
  end

  assign cmd_o     = op_q ? FORCE_ON : FORCE_OFF;
  assign tmr_en_o  = (st_q == S_WAIT);
  assign busy_o    = (st_q != S_IDLE);
  assign done_o    = (st_q == S_FIN);
  assign err_o     = done_o && err_q;
  assign timeout_o = done_o && tmo_q;
endmodule

// File: rtl/pwr_rail_seq.sv
module pwr_rail_seq
  import pwr_seq_pkg::*;
#(
  parameter int unsigned CYCLES_PER_MS = 50000,
  parameter int unsigned TIMEOUT_MS    = 1,
  parameter bit          CHECK_SEL     = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       op_on_i,
  input  logic [1:0] rail_sel_i,
  input  logic [3:0] sw_busy_i,
  input  logic [3:0] logic_gate_st_i,
  input  logic [3:0] logic_sel_st_i,
  input  logic [3:0] array_gate_st_i,
  input  logic [3:0] array_sel_st_i,
  output logic [1:0] logic_force_o,
  output logic [1:0] array_force_o,
  output logic       logic_val_ovr_o,
  output logic       logic_sel_ovr_o,
  output logic       logic_reg_en_o,
  output logic       array_val_ovr_o,
  output logic       array_sel_ovr_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o,
  output logic       timeout_o
);
  localparam int unsigned TMO_CYCLES = CYCLES_PER_MS * TIMEOUT_MS;

  logic [NRAIL-1:0] act_w, idle_w, selok_w;
  logic [3:0]       gate_w [NRAIL];
  logic [3:0]       sel_w  [NRAIL];
  logic [1:0]       force_w[NRAIL];
  logic [1:0]       cmd_w;
  logic             tmr_en_w, tmo_w;

  assign gate_w[RAIL_LOGIC] = logic_gate_st_i;
  assign gate_w[RAIL_ARRAY] = array_gate_st_i;
  assign sel_w[RAIL_LOGIC]  = logic_sel_st_i;
  assign sel_w[RAIL_ARRAY]  = array_sel_st_i;

  pwr_seq_ctl #(.CHECK_SEL(CHECK_SEL)) u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .op_on_i      (op_on_i),
    .rail_sel_i   (rail_sel_i),
    .sw_busy_i    (sw_busy_i),
    .rail_idle_i  (idle_w),
    .rail_selok_i (selok_w),
    .tmo_i        (tmo_w),
    .rail_act_o   (act_w),
    .cmd_o        (cmd_w),
    .tmr_en_o     (tmr_en_w),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o),
    .timeout_o    (timeout_o)
  );

  pwr_seq_timer #(.LIMIT(TMO_CYCLES)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (tmr_en_w),
    .expired_o (tmo_w)
  );

  for (genvar r = 0; r < NRAIL; r++) begin : g_rail
    pwr_seq_rail_drv u_drv (
      .act_i     (act_w[r]),
      .cmd_i     (cmd_w),
      .gate_st_i (gate_w[r]),
      .sel_st_i  (sel_w[r]),
      .force_o   (force_w[r]),
      .idle_o    (idle_w[r]),
      .selok_o   (selok_w[r])
    );
  end

  assign logic_force_o   = force_w[RAIL_LOGIC];
  assign array_force_o   = force_w[RAIL_ARRAY];
  assign logic_val_ovr_o = 1'b0;
  assign logic_sel_ovr_o = 1'b0;
  assign logic_reg_en_o  = 1'b0;
  assign array_val_ovr_o = 1'b0;
  assign array_sel_ovr_o = 1'b0;
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic [3:0] sw_busy_i,
  input logic [1:0] logic_force_o,
  input logic [1:0] array_force_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o,
  input logic       timeout_o
);
  // R3
  one_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(logic_force_o != 2'b00 && array_force_o != 2'b00));

  // R3
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    logic_force_o != 2'b10 && array_force_o != 2'b10);

  // R7
  gap_logic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (logic_force_o != 2'b00) |=> (array_force_o == 2'b00));

  // R7
  gap_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (array_force_o != 2'b00) |=> (logic_force_o == 2'b00));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R4
  refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && sw_busy_i != 4'b0000) |=>
      (done_o && err_o && logic_force_o == 2'b00 && array_force_o == 2'b00));

  // R6
  tmo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (logic_force_o == 2'b00 && array_force_o == 2'b00 && !err_o));
endmodule

bind pwr_rail_seq pwr_seq_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .sw_busy_i     (sw_busy_i),
  .logic_force_o (logic_force_o),
  .array_force_o (array_force_o),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .err_o         (err_o),
  .timeout_o     (timeout_o)
);

// File: tb/test_pwr_rail_seq.sv
`timescale 1ns/1ps
module test_pwr_rail_seq;
  localparam int unsigned CPM = 60;
  localparam int unsigned TMO = CPM * 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic op_on_i = 1'b0;
  logic [1:0] rail_sel_i = 2'b00;
  logic [3:0] sw_busy_i = 4'b0000;
  logic [3:0] gst [2];
  logic [3:0] sst [2];
  logic [1:0] logic_force_o, array_force_o;
  logic logic_val_ovr_o, logic_sel_ovr_o, logic_reg_en_o, array_val_ovr_o, array_sel_ovr_o;
  logic busy_o, done_o, err_o, timeout_o;

  always #10 clk = ~clk;

  pwr_rail_seq #(.CYCLES_PER_MS(CPM), .TIMEOUT_MS(1), .CHECK_SEL(1'b1)) i_pwr_rail_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_on_i(op_on_i),
    .rail_sel_i(rail_sel_i), .sw_busy_i(sw_busy_i),
    .logic_gate_st_i(gst[0]), .logic_sel_st_i(sst[0]),
    .array_gate_st_i(gst[1]), .array_sel_st_i(sst[1]),
    .logic_force_o(logic_force_o), .array_force_o(array_force_o),
    .logic_val_ovr_o(logic_val_ovr_o), .logic_sel_ovr_o(logic_sel_ovr_o),
    .logic_reg_en_o(logic_reg_en_o), .array_val_ovr_o(array_val_ovr_o),
    .array_sel_ovr_o(array_sel_ovr_o), .busy_o(busy_o), .done_o(done_o),
    .err_o(err_o), .timeout_o(timeout_o)
  );

  // switch controller responders: rail 0 = logic, rail 1 = array
  int  dly [2];
  bit  hang [2];
  bit  bad [2];
  int  rcnt [2];
  bit  ract [2];
  bit  rfin [2];
  logic [1:0] fz [2];
  assign fz[0] = logic_force_o;
  assign fz[1] = array_force_o;

  always @(posedge clk or negedge rst_n) begin
    for (int r = 0; r < 2; r++) begin
      if (!rst_n) begin
        gst[r] <= 4'b1000; sst[r] <= 4'h8; ract[r] <= 1'b0; rfin[r] <= 1'b0; rcnt[r] <= 0;
      end else if (fz[r] == 2'b00) begin
        gst[r] <= 4'b1000; sst[r] <= 4'h8; ract[r] <= 1'b0; rfin[r] <= 1'b0;
      end else if (!ract[r] && !rfin[r]) begin
        ract[r] <= 1'b1; rcnt[r] <= dly[r]; gst[r] <= 4'b0001; sst[r] <= 4'h3;
      end else if (ract[r] && !hang[r]) begin
        if (rcnt[r] == 0) begin
          gst[r] <= 4'b1000; sst[r] <= bad[r] ? 4'h5 : 4'h8; ract[r] <= 1'b0; rfin[r] <= 1'b1;
        end else begin
          rcnt[r] <= rcnt[r] - 1;
        end
      end
    end
  end

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected outcome
  int exp_n, exp_rail[2], exp_cmd[2];
  bit exp_err, exp_tmo;

  task automatic compute_exp(input bit op, input logic [1:0] sel, input logic [3:0] bz);
    int order[2];
    int cnt;
    exp_n = 0; exp_err = 0; exp_tmo = 0;
    if (bz != 4'b0000 || sel == 2'b00) begin
      exp_err = 1;
      return;
    end
    cnt = 0;
    if (sel == 2'b11) begin
      order[0] = op ? 0 : 1; order[1] = op ? 1 : 0; cnt = 2;
    end else begin
      order[0] = sel[0] ? 0 : 1; cnt = 1;
    end
    for (int i = 0; i < cnt; i++) begin
      exp_rail[exp_n] = order[i];
      exp_cmd[exp_n] = op ? 3 : 1;
      exp_n++;
      if (hang[order[i]]) begin exp_tmo = 1; return; end
      if (bad[order[i]]) begin exp_err = 1; return; end
    end
  endtask

  task automatic run_case(input bit op, input logic [1:0] sel, input logic [3:0] bz,
                          input bit mid_start, input int tmo_exact);
    int got_n, got_rail[2], got_cmd[2], cyc;
    bit mutual_bad, gap_bad, ovr_bad, seen_done;
    logic [1:0] prev [2];
    compute_exp(op, sel, bz);
    got_n = 0; mutual_bad = 0; gap_bad = 0; ovr_bad = 0; seen_done = 0; cyc = 0;
    prev[0] = 2'b00; prev[1] = 2'b00;
    @(negedge clk);
    start_i = 1'b1; op_on_i = op; rail_sel_i = sel; sw_busy_i = bz;
    @(negedge clk);
    start_i = 1'b0;
    while (cyc < 2 * TMO + 200) begin
      cyc++;
      if (mid_start && cyc == 3) begin start_i = 1'b1; op_on_i = ~op; rail_sel_i = 2'b11; end
      if (mid_start && cyc == 4) start_i = 1'b0;
      for (int r = 0; r < 2; r++) begin
        if (fz[r] != 2'b00 && prev[r] == 2'b00 && got_n < 2) begin
          got_rail[got_n] = r; got_cmd[got_n] = int'(fz[r]); got_n++;
        end
      end
      if (fz[0] != 2'b00 && fz[1] != 2'b00) mutual_bad = 1;
      if ((prev[0] != 2'b00 && fz[1] != 2'b00) || (prev[1] != 2'b00 && fz[0] != 2'b00)) gap_bad = 1;
      if (logic_val_ovr_o | logic_sel_ovr_o | logic_reg_en_o | array_val_ovr_o | array_sel_ovr_o) ovr_bad = 1;
      if (done_o) begin seen_done = 1; break; end
      prev[0] = fz[0]; prev[1] = fz[1];
      @(negedge clk);
    end
    check(seen_done, "R11 done seen (watchdog)", int'(seen_done), 1);
    check(err_o == exp_err, "R4/R9/R10 err flag", int'(err_o), int'(exp_err));
    check(timeout_o == exp_tmo, "R6 timeout flag", int'(timeout_o), int'(exp_tmo));
    check(got_n == exp_n, "R10 rails commanded", got_n, exp_n);
    for (int i = 0; i < 2; i++) begin
      if (i < exp_n && i < got_n) begin
        check(got_rail[i] == exp_rail[i], op ? "R1 rail order" : "R2 rail order", got_rail[i], exp_rail[i]);
        check(got_cmd[i] == exp_cmd[i], "R3 force code", got_cmd[i], exp_cmd[i]);
      end
    end
    check(!mutual_bad, "R3 one rail at a time", int'(mutual_bad), 0);
    check(!gap_bad, "R7 release gap", int'(gap_bad), 0);
    check(!ovr_bad, "R8 overrides low", int'(ovr_bad), 0);
    if (exp_tmo) check(logic_force_o == 2'b00 && array_force_o == 2'b00, "R6 forces cleared",
                       int'({logic_force_o, array_force_o}), 0);
    if (tmo_exact > 0) check(cyc == tmo_exact, "R6 timeout cycle", cyc, tmo_exact);
    if (exp_n > 0 && !exp_tmo) check(cyc >= dly[exp_rail[0]] + 3, "R5 waits for idle", cyc, dly[exp_rail[0]] + 3);
    @(negedge clk);
    check(!done_o && !busy_o, "R11 single done pulse", int'({done_o, busy_o}), 0);
    @(negedge clk);
    check(!done_o, "R11 no second done", int'(done_o), 0);
  endtask

  task automatic set_rails(input int d0, input int d1, input bit h0, input bit h1, input bit b0, input bit b1);
    dly[0] = d0; dly[1] = d1; hang[0] = h0; hang[1] = h1; bad[0] = b0; bad[1] = b1;
  endtask

  initial begin
    set_rails(2, 2, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(logic_force_o == 2'b00 && array_force_o == 2'b00, "R12 forces idle", int'({logic_force_o, array_force_o}), 0);
    check(!busy_o && !done_o && !err_o && !timeout_o, "R12 status idle",
          int'({busy_o, done_o, err_o, timeout_o}), 0);

    // directed corners
    set_rails(4, 6, 0, 0, 0, 0); run_case(1'b1, 2'b11, 4'b0000, 0, 0);   // R1
    set_rails(4, 6, 0, 0, 0, 0); run_case(1'b0, 2'b11, 4'b0000, 0, 0);   // R2
    set_rails(3, 3, 0, 0, 0, 0); run_case(1'b1, 2'b11, 4'b0100, 0, 0);   // R4
    set_rails(3, 3, 0, 0, 0, 0); run_case(1'b1, 2'b01, 4'b0000, 0, 0);   // R10 logic only
    set_rails(3, 3, 0, 0, 0, 0); run_case(1'b0, 2'b10, 4'b0000, 0, 0);   // R10 array only
    set_rails(3, 3, 0, 0, 0, 0); run_case(1'b1, 2'b00, 4'b0000, 0, 0);   // R10 none
    set_rails(3, 3, 1, 0, 0, 0); run_case(1'b1, 2'b11, 4'b0000, 0, TMO + 1); // R6 exact
    set_rails(3, 3, 0, 1, 0, 0); run_case(1'b1, 2'b11, 4'b0000, 0, 0);   // R6 second rail
    set_rails(3, 3, 0, 1, 0, 0); run_case(1'b1, 2'b11, 4'b0000, 0, 0);   // R6 second rail repeat
    set_rails(TMO - 10, 2, 0, 0, 0, 0); run_case(1'b1, 2'b01, 4'b0000, 0, 0); // R5 long delay
    set_rails(3, 3, 0, 0, 0, 1); run_case(1'b0, 2'b11, 4'b0000, 0, 0);   // R9 first rail bad
    set_rails(5, 5, 0, 0, 0, 0); run_case(1'b1, 2'b11, 4'b0000, 1, 0);   // R11 start while busy

    // constrained random
    void'($urandom(32'd1234));
    for (int k = 0; k < 60; k++) begin
      bit op;
      logic [1:0] sel;
      logic [3:0] bz;
      op  = 1'($urandom_range(0, 1));
      sel = ($urandom_range(0, 11) == 0) ? 2'b00 : 2'($urandom_range(1, 3));
      bz  = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(1, 15)) : 4'b0000;
      set_rails($urandom_range(0, 15), $urandom_range(0, 15),
                ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0),
                ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0));
      run_case(op, sel, bz, ($urandom_range(0, 5) == 0), 0);
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule